// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32.768 kHz timebase into a periodic interrupt whose rate is picked by a 4-bit code. A free-running 15-bit prescale counter advances once per timebase pulse. A tick is raised when the low bits of that counter, as many as the chosen period needs, wrap to zero. Ticks therefore land on exact multiples of the period and not at a fixed distance from the moment the interrupt was enabled.

Each tick latches a periodic flag and a master interrupt flag, and drives the interrupt request line. A status read strobe from the host clears all three. A divider-hold input keeps the prescaler at zero and stops ticks while it is high. All control inputs are expected to come already registered from the host-side register file.

Top module: `periodic_irq_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), per_flag, irq_flag and irq are all 0 and the prescale counter is 0.
- R2: For rate_code 3 to 15, a tick happens on the timebase pulse that brings the prescale count to a nonzero-or-wrapped multiple of 2^(rate_code−1). The count is the number of timebase pulses since reset or divider hold, modulo 32768.
- R3: rate_code 1 gives a period of 128 timebase pulses and rate_code 2 gives 256, the same as codes 8 and 9.
- R4: rate_code 0 produces no ticks.
- R5: While per_en is 0 no tick occurs and the flags keep their values.
- R6: A tick sets per_flag, irq_flag and irq to 1 on the clock edge that samples the timebase pulse.
- R7: A stat_rd pulse clears per_flag, irq_flag and irq at that edge. When a tick falls on the same edge, the tick wins and all three end up set.
- R8: While div_hold is 1 the prescale counter is held at 0 and no tick occurs. After release, the first tick comes one full period of timebase pulses later.
- R9: A change of rate_code takes effect at the next multiple of the new period on the free-running count, with no partial or extra tick.
- R10: Without a tick or a stat_rd, per_flag, irq_flag and irq hold their values from one clock to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbase_tick | input | 1 | One-cycle pulse per 32.768 kHz timebase period |
| rate_code | input | 4 | Period select code (0 means off) |
| per_en | input | 1 | Periodic interrupt enable |
| div_hold | input | 1 | Holds the prescaler in reset and stops ticks |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| per_flag | output | 1 | Periodic flag |
| irq_flag | output | 1 | Master interrupt flag |
| irq | output | 1 | Interrupt request line, active high |

## Verification
The bench uses the default 15-bit prescaler and drives a timebase pulse on nearly every clock. This makes even the longest period (16384 pulses) cheap to cover, so it sweeps every one of the 16 rate codes and sees at least two ticks on each nonzero code. An arithmetic model of the count modulo 32768 gives the expected flags on every clock. Against that model the bench checks divider-hold release, rate changes in mid-period, disabling, read/tick collisions and flag holding.

// File: rtl/pig_pkg.sv
// Package for the periodic interrupt generator.
// Holds the rate-code width and the mapping from rate code to the number of
// prescale bits that must wrap to zero for a tick.
package pig_pkg;
    localparam int CODE_W = 4;

    // Map a rate code to its wrap-bit count; 0 means the code is disabled.
    function automatic logic [CODE_W-1:0] rate_shift(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] sh;
        case (code)
            4'd0:    sh = 4'd0;
            4'd1:    sh = 4'd7;   // aliases to code 8
            4'd2:    sh = 4'd8;   // aliases to code 9
            default: sh = code - 4'd1;
        endcase
        return sh;
    endfunction
endpackage

// File: rtl/pig_prescaler.sv
// Free-running prescale counter of the timebase.
// Assumes tbase_tick is a single-cycle pulse synchronous to clk.
// div_hold forces the count to zero and blocks advancing.
module pig_prescaler #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbase_tick,
    input  logic             div_hold,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             adv
);
    // Advance qualifier and next count value.
    always_comb begin
        adv     = tbase_tick & ~div_hold;
        cnt_nxt = cnt + 1'b1;
    end

    // Counter register: cleared by reset or divider hold.
    always_ff @(posedge clk) begin
        if (!rst_n || div_hold) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/pig_tick_sel.sv
// Tick selector: raises tick when the advancing count wraps its low
// (effective code - 1) bits to zero. Assumes CNT_W >= 15 so every code fits.
module pig_tick_sel #(
    parameter int CNT_W = 15
) (
    input  logic                       adv,
    input  logic [CNT_W-1:0]           cnt_nxt,
    input  logic [pig_pkg::CODE_W-1:0] rate_code,
    input  logic                       per_en,
    output logic                       tick
);
    logic [CNT_W-1:0]           wrap;
    logic [pig_pkg::CODE_W-1:0] shift;

    assign wrap[0] = 1'b0;
    // One wrap detector per possible boundary width.
    for (genvar s = 1; s < CNT_W; s++) begin : g_wrap
        assign wrap[s] = (cnt_nxt[s-1:0] == '0);
    end

    // Select the detector for the current code and qualify it.
    always_comb begin
        shift = pig_pkg::rate_shift(rate_code);
        tick  = adv & per_en & (rate_code != '0) & wrap[shift];
    end
endmodule

// File: rtl/pig_status.sv
// Status flags: a tick sets the periodic and master flags and the request
// line; a status read clears them. A tick on the read edge takes priority.
module pig_status (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stat_rd,
    output logic per_flag,
    output logic irq_flag,
    output logic irq
);
    // Flag registers with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_flag <= 1'b0;
            irq_flag <= 1'b0;
            irq      <= 1'b0;
        end else if (tick) begin
            per_flag <= 1'b1;
            irq_flag <= 1'b1;
            irq      <= 1'b1;
        end else if (stat_rd) begin
            per_flag <= 1'b0;
            irq_flag <= 1'b0;
            irq      <= 1'b0;
        end
    end
endmodule

// File: rtl/periodic_irq_gen.sv
// Top of the periodic interrupt generator. Assumes all control inputs are
// registered in the host register file and tbase_tick is a one-cycle pulse.
module periodic_irq_gen #(
    parameter int CNT_W = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tbase_tick,
    input  logic [pig_pkg::CODE_W-1:0] rate_code,
    input  logic                       per_en,
    input  logic                       div_hold,
    input  logic                       stat_rd,
    output logic                       per_flag,
    output logic                       irq_flag,
    output logic                       irq
);
    logic [CNT_W-1:0] pre_cnt;
    logic [CNT_W-1:0] pre_nxt;
    logic             pre_adv;
    logic             tick;

    pig_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tbase_tick(tbase_tick), .div_hold(div_hold),
        .cnt(pre_cnt), .cnt_nxt(pre_nxt), .adv(pre_adv)
    );

    pig_tick_sel #(.CNT_W(CNT_W)) u_sel (
        .adv(pre_adv), .cnt_nxt(pre_nxt), .rate_code(rate_code),
        .per_en(per_en), .tick(tick)
    );

    pig_status u_stat (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stat_rd(stat_rd),
        .per_flag(per_flag), .irq_flag(irq_flag), .irq(irq)
    );
endmodule

// File: rtl/pig_checker.sv
// Property checker for periodic_irq_gen, attached by bind.
module pig_checker #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             per_en,
    input logic             div_hold,
    input logic             stat_rd,
    input logic             tick,
    input logic [CNT_W-1:0] pre_cnt,
    input logic             per_flag,
    input logic             irq_flag,
    input logic             irq
);
    AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (per_flag && irq_flag && irq)); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !tick) |=> (!per_flag && !irq_flag && !irq)); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !stat_rd) |=> $stable({per_flag, irq_flag, irq})); // R10
    AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        div_hold |=> (pre_cnt == '0)); // R8
    AST_TICK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_cnt[1:0] == 2'b00)); // R2
    AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_en || div_hold) |-> !tick); // R5
endmodule

bind periodic_irq_gen pig_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .per_en(per_en), .div_hold(div_hold),
    .stat_rd(stat_rd), .tick(tick), .pre_cnt(pre_cnt),
    .per_flag(per_flag), .irq_flag(irq_flag), .irq(irq)
);

// File: tb/sim_periodic_irq_gen.sv
module sim_periodic_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tbase_tick = 1'b0;
    logic [3:0] rate_code = 4'd6;
    logic       per_en = 1'b0;
    logic       div_hold = 1'b0;
    logic       stat_rd = 1'b0;
    logic       per_flag, irq_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mcnt = 0;
    bit mflag = 0;
    int nticks = 0;

    always #2 clk = ~clk;

    periodic_irq_gen u0 (
        .clk(clk), .rst_n(rst_n), .tbase_tick(tbase_tick), .rate_code(rate_code),
        .per_en(per_en), .div_hold(div_hold), .stat_rd(stat_rd),
        .per_flag(per_flag), .irq_flag(irq_flag), .irq(irq)
    );

    function automatic int period_of(input int code);
        int eff;
        eff = (code == 1) ? 8 : (code == 2) ? 9 : code;
        return 1 << (eff - 1);
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flags actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive pulse/read, update model, compare after the edge.
    task automatic cyc(input logic t, input logic r, input string req);
        bit tk;
        tbase_tick = t;
        stat_rd = r;
        @(posedge clk);
        tk = 0;
        if (div_hold) mcnt = 0;
        else if (t) begin
            mcnt = (mcnt + 1) % 32768;
            tk = per_en && (rate_code != 0) && (mcnt % period_of(rate_code) == 0);
        end
        if (tk) begin mflag = 1; nticks++; end
        else if (r) mflag = 0;
        #1;
        check(req, {per_flag, irq_flag, irq}, {3{mflag}});
        tbase_tick = 0;
        stat_rd = 0;
    endtask

    task automatic hold_div();
        div_hold = 1;
        cyc(1, 1, "R8");
        div_hold = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {per_flag, irq_flag, irq}, 3'b000);
        rst_n = 1;
        mcnt = 0;
        mflag = 0;

        // R2 R3 R4: sweep all codes, two periods each from a held divider
        for (int c = 0; c < 16; c++) begin
            string tag;
            int n;
            rate_code = c[3:0];
            per_en = 1;
            hold_div();
            tag = (c == 0) ? "R4" : (c < 3) ? "R3" : "R2";
            nticks = 0;
            n = (c == 0) ? 300 : 2 * period_of(c) + 2;
            for (int i = 0; i < n; i++) cyc(1, (i % 37) == 5, tag);
            checks++;
            if (nticks != ((c == 0) ? 0 : 2)) begin
                errors++;
                $display("FAIL %s: tick count actual=%0d expected=%0d code=%0d",
                         tag, nticks, (c == 0) ? 0 : 2, c);
            end
        end

        // R6 R7: tick and read on the same edge; tick must win
        rate_code = 4'd3;
        hold_div();
        for (int i = 0; i < 3; i++) cyc(1, 0, "R6");
        cyc(1, 1, "R7");
        cyc(0, 1, "R7");
        cyc(0, 0, "R10");

        // R5 R10: disable with flag set; flags hold, no tick
        for (int i = 0; i < 4; i++) cyc(1, 0, "R6");
        per_en = 0;
        for (int i = 0; i < 40; i++) cyc(1, 0, "R5");
        cyc(1, 1, "R7");
        for (int i = 0; i < 40; i++) cyc(1, 0, "R5");
        per_en = 1;

        // R9: rate change mid period, gaps in the timebase
        rate_code = 4'd7;
        hold_div();
        for (int i = 0; i < 40; i++) cyc(1, (i % 9) == 0, "R9");
        rate_code = 4'd4;
        for (int i = 0; i < 60; i++) cyc(i % 3 != 0, (i % 5) == 0, "R9");
        rate_code = 4'd6;
        for (int i = 0; i < 200; i++) cyc(1, (i % 11) == 0, "R9");

        // R8: divider hold for several cycles, then one full period to first tick
        div_hold = 1;
        for (int i = 0; i < 10; i++) cyc(1, 0, "R8");
        div_hold = 0;
        cyc(0, 1, "R8");
        for (int i = 0; i < 70; i++) cyc(1, 0, "R8");

        // R1: reset in operation clears flags
        rst_n = 0;
        @(posedge clk);
        #1;
        check("R1", {per_flag, irq_flag, irq}, 3'b000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule